// File: doc/BRIEF.md
# NAND Program Order Monitor

This block watches the stream of confirmed program and erase operations sent to a NAND flash array and checks each one against the array's programming rules. Every operation arrives as a single-cycle strobe carrying an erase/program flag, a block index, a page index and the level of the write-protect line. For each erase block the monitor remembers the highest page programmed since the last erase and how many partial programs that page has received.

A program to a page below the block's highest page breaks the ascending-order rule. A program to the highest page itself counts as one more partial program, and this is refused once the per-page cap is reached. Any operation issued while write protect is active (`wp_n` low) is refused. A refused operation leaves the tracking state as it was. The cycle after each operation, the block raises a one-cycle violation pulse with a two-bit reason code, or stays quiet if the operation was legal. An erase returns its block to the empty state.

Top module: `nand_pom`

## Requirements
- R1: After reset every block is empty, `viol` is 0 and `viol_code` is 0. The first program of any page in an empty block is legal.
- R2: The verdict for an operation appears the cycle after `op_valid`, for one cycle only. In cycles after no operation, `viol` is 0 and `viol_code` is 0. Whenever `viol` is 0, `viol_code` is 0.
- R3: An operation with `wp_n` low reports code 3 (write protect) and changes no tracking state. This applies to program and to erase.
- R4: A program to a page higher than the block's highest page, or to any page of an empty block, is legal (code 0). That page becomes the highest page, with a partial count of 1.
- R5: A program to a page lower than the block's highest page reports code 1 (order) and changes no state.
- R6: A program to the block's highest page is legal while its partial count is below `MAX_PARTIAL`, and raises the count by one. When the count equals `MAX_PARTIAL`, the program reports code 2 (partial overflow) and the count stays the same.
- R7: An erase with `wp_n` high is legal (code 0). It empties the block, which clears its highest-page pointer and its partial count.
- R8: Each block's tracking state is changed only by operations addressed to that block.
- R9: Write protect has priority. An operation with `wp_n` low reports code 3 even when it would otherwise be an order or partial violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle strobe marking a confirmed operation |
| op_erase | input | 1 | 1 = block erase, 0 = page program |
| op_block | input | $clog2(NUM_BLOCKS) | Erase block index |
| op_page | input | $clog2(PAGES_PER_BLOCK) | Page index within the block (ignored for erase) |
| wp_n | input | 1 | Write-protect level; low forbids the operation |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 2 | 0 none, 1 order, 2 partial overflow, 3 write protect |

## Verification
The hardest condition to reach is a partial-overflow refusal that follows many legal partial programs, an out-of-order page and an erase in the same block. Random stimulus seldom lines up that many hits on one page. The bench therefore uses a small configuration (4 blocks, 8 pages, a cap of 3) and sweeps every ordered pair of pages in every block, each pair starting from a fresh erase. It then runs a random phase whose page choices cluster around the block's current highest page, so that repeats and overflows occur often. A bench-side model that is written separately from the design predicts every verdict.

// File: rtl/nand_pom_pkg.sv
package nand_pom_pkg;
  typedef enum logic [1:0] {
    VC_NONE    = 2'd0,
    VC_ORDER   = 2'd1,
    VC_PARTIAL = 2'd2,
    VC_WPROT   = 2'd3
  } viol_code_e;
endpackage

// File: rtl/nand_pom_table.sv
// Per-block tracking state: empty flag, highest programmed page, and the partial count of that page.
module nand_pom_table #(
  parameter int NUM_BLOCKS = 2048,
  parameter int PAGE_W     = 6,
  parameter int CNT_W      = 4,
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  sel_blk,
  output logic              rd_valid,
  output logic [PAGE_W-1:0] rd_hi,
  output logic [CNT_W-1:0]  rd_cnt,
  input  logic              wr_en,
  input  logic              wr_valid,
  input  logic [PAGE_W-1:0] wr_hi,
  input  logic [CNT_W-1:0]  wr_cnt
);
  logic              used_q [NUM_BLOCKS];
  logic [PAGE_W-1:0] hi_q   [NUM_BLOCKS];
  logic [CNT_W-1:0]  cnt_q  [NUM_BLOCKS];

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic hit;
    assign hit = wr_en && (sel_blk == BLK_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        used_q[b] <= 1'b0;
        hi_q[b]   <= '0;
        cnt_q[b]  <= '0;
      end else if (hit) begin
        used_q[b] <= wr_valid;
        hi_q[b]   <= wr_hi;
        cnt_q[b]  <= wr_cnt;
      end
    end
  end

  assign rd_valid = used_q[sel_blk];
  assign rd_hi    = hi_q[sel_blk];
  assign rd_cnt   = cnt_q[sel_blk];
endmodule

// File: rtl/nand_pom_rule.sv
// Combinational verdict and next-state for one operation against one block entry.
module nand_pom_rule
  import nand_pom_pkg::*;
#(
  parameter int PAGE_W      = 6,
  parameter int CNT_W       = 4,
  parameter int MAX_PARTIAL = 8
) (
  input  logic              op_valid,
  input  logic              op_erase,
  input  logic              wp_n,
  input  logic [PAGE_W-1:0] op_page,
  input  logic              ent_valid,
  input  logic [PAGE_W-1:0] ent_hi,
  input  logic [CNT_W-1:0]  ent_cnt,
  output viol_code_e        code,
  output logic              upd_en,
  output logic              nxt_valid,
  output logic [PAGE_W-1:0] nxt_hi,
  output logic [CNT_W-1:0]  nxt_cnt,
  output logic              ev_wp,
  output logic              ev_lower,
  output logic              ev_over,
  output logic              ev_advance,
  output logic              ev_erase
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_PARTIAL);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic at_cap(input logic [CNT_W-1:0] c);
    return c >= CAP;
  endfunction

  logic prog, same;

  always_comb begin
    prog       = op_valid && wp_n && !op_erase;
    ev_wp      = op_valid && !wp_n;
    ev_erase   = op_valid && wp_n && op_erase;
    ev_lower   = prog && ent_valid && (op_page < ent_hi);
    same       = prog && ent_valid && (op_page == ent_hi);
    ev_over    = same && at_cap(ent_cnt);
    ev_advance = prog && (!ent_valid || (op_page > ent_hi));

    if (ev_wp)         code = VC_WPROT;
    else if (ev_lower) code = VC_ORDER;
    else if (ev_over)  code = VC_PARTIAL;
    else               code = VC_NONE;

    upd_en    = ev_erase || ev_advance || (same && !ev_over);
    nxt_valid = !ev_erase;
    nxt_hi    = ev_erase ? '0 : op_page;
    if (ev_erase)        nxt_cnt = '0;
    else if (ev_advance) nxt_cnt = CNT_W'(1);
    else                 nxt_cnt = bump(ent_cnt);
  end
endmodule

// File: rtl/nand_pom.sv
module nand_pom
  import nand_pom_pkg::*;
#(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MAX_PARTIAL     = 8,
  parameter int BLK_W           = $clog2(NUM_BLOCKS),
  parameter int PAGE_W          = $clog2(PAGES_PER_BLOCK),
  parameter int CNT_W           = $clog2(MAX_PARTIAL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_erase,
  input  logic [BLK_W-1:0]  op_block,
  input  logic [PAGE_W-1:0] op_page,
  input  logic              wp_n,
  output logic              viol,
  output logic [1:0]        viol_code
);
  logic              ent_valid;
  logic [PAGE_W-1:0] ent_hi;
  logic [CNT_W-1:0]  ent_cnt;
  viol_code_e        code;
  logic              upd_en, nxt_valid;
  logic [PAGE_W-1:0] nxt_hi;
  logic [CNT_W-1:0]  nxt_cnt;
  logic              ev_wp, ev_lower, ev_over, ev_advance, ev_erase;

  nand_pom_table #(
    .NUM_BLOCKS(NUM_BLOCKS), .PAGE_W(PAGE_W), .CNT_W(CNT_W), .BLK_W(BLK_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .sel_blk(op_block),
    .rd_valid(ent_valid), .rd_hi(ent_hi), .rd_cnt(ent_cnt),
    .wr_en(upd_en), .wr_valid(nxt_valid), .wr_hi(nxt_hi), .wr_cnt(nxt_cnt)
  );

  nand_pom_rule #(
    .PAGE_W(PAGE_W), .CNT_W(CNT_W), .MAX_PARTIAL(MAX_PARTIAL)
  ) u_rule (
    .op_valid(op_valid), .op_erase(op_erase), .wp_n(wp_n), .op_page(op_page),
    .ent_valid(ent_valid), .ent_hi(ent_hi), .ent_cnt(ent_cnt),
    .code(code), .upd_en(upd_en), .nxt_valid(nxt_valid), .nxt_hi(nxt_hi),
    .nxt_cnt(nxt_cnt), .ev_wp(ev_wp), .ev_lower(ev_lower), .ev_over(ev_over),
    .ev_advance(ev_advance), .ev_erase(ev_erase)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= VC_NONE;
    end else begin
      viol      <= (code != VC_NONE);
      viol_code <= code;
    end
  end
endmodule

// File: rtl/nand_pom_chk.sv
module nand_pom_chk #(
  parameter int PAGE_W      = 6,
  parameter int CNT_W       = 4,
  parameter int MAX_PARTIAL = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_erase,
  input logic              wp_n,
  input logic [PAGE_W-1:0] op_page,
  input logic              ent_valid,
  input logic [PAGE_W-1:0] ent_hi,
  input logic [CNT_W-1:0]  ent_cnt,
  input logic              viol,
  input logic [1:0]        viol_code
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!viol && viol_code == 2'd0)); // R2
  AST_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> viol_code == 2'd0); // R2
  AST_WP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wp_n) |=> (viol && viol_code == 2'd3)); // R3
  AST_ORDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wp_n && !op_erase && ent_valid && op_page < ent_hi)
      |=> (viol && viol_code == 2'd1)); // R5
  AST_PARTIAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wp_n && !op_erase && ent_valid && op_page == ent_hi &&
     ent_cnt == CNT_W'(MAX_PARTIAL)) |=> (viol && viol_code == 2'd2)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ent_cnt <= CNT_W'(MAX_PARTIAL)); // R6
  AST_ERASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wp_n && op_erase) |=> !viol); // R7
  AST_WP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wp_n && !op_erase && ent_valid && op_page < ent_hi)
      |=> viol_code == 2'd3); // R9
endmodule

bind nand_pom nand_pom_chk #(
  .PAGE_W(PAGE_W), .CNT_W(CNT_W), .MAX_PARTIAL(MAX_PARTIAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_erase(op_erase),
  .wp_n(wp_n), .op_page(op_page), .ent_valid(ent_valid), .ent_hi(ent_hi),
  .ent_cnt(ent_cnt), .viol(viol), .viol_code(viol_code)
);

// File: tb/sim_nand_pom.sv
`timescale 1ns/1ps
module sim_nand_pom;
  localparam int NB = 4, NP = 8, MAXP = 3, BW = 2, PW = 3;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0, op_erase = 1'b0, wp_n = 1'b1;
  logic [BW-1:0] op_block = '0;
  logic [PW-1:0] op_page = '0;
  logic viol;
  logic [1:0] viol_code;

  always #2.5 clk = ~clk;

  nand_pom #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(NP), .MAX_PARTIAL(MAXP)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_erase(op_erase),
    .op_block(op_block), .op_page(op_page), .wp_n(wp_n),
    .viol(viol), .viol_code(viol_code));

  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit m_used [NB];
  int m_hi [NB];
  int m_cnt [NB];
  string m_tag;

  // Reference model: returns the expected code and updates the model state.
  function automatic int predict(bit er, int b, int p, bit wp);
    if (!wp) begin m_tag = "R3"; return 3; end
    if (er) begin m_tag = "R7"; m_used[b] = 0; m_hi[b] = 0; m_cnt[b] = 0; return 0; end
    if (!m_used[b] || p > m_hi[b]) begin
      m_tag = "R4"; m_used[b] = 1; m_hi[b] = p; m_cnt[b] = 1; return 0;
    end
    if (p < m_hi[b]) begin m_tag = "R5"; return 1; end
    m_tag = "R6";
    if (m_cnt[b] >= MAXP) return 2;
    m_cnt[b]++;
    return 0;
  endfunction

  task automatic check(string req, int act_v, int act_c, int exp_v, int exp_c);
    checks++;
    if (act_v != exp_v || act_c != exp_c) begin
      fails++;
      $display("FAIL %s: viol=%0d code=%0d expected viol=%0d code=%0d",
               req, act_v, act_c, exp_v, exp_c);
    end
  endtask

  // Called at a negedge: drives one operation, checks its verdict one cycle later.
  task automatic do_op(bit er, int b, int p, bit wp, string req);
    int e;
    op_valid = 1'b1; op_erase = er; op_block = BW'(b); op_page = PW'(p); wp_n = wp;
    e = predict(er, b, p, wp);
    @(negedge clk);
    op_valid = 1'b0; wp_n = 1'b1;
    check(req == "" ? m_tag : req, int'(viol), int'(viol_code), (e != 0) ? 1 : 0, e);
  endtask

  task automatic idle_check(string req);
    @(negedge clk);
    check(req, int'(viol), int'(viol_code), 0, 0);
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) begin m_used[i] = 0; m_hi[i] = 0; m_cnt[i] = 0; end
    repeat (4) @(negedge clk);
    check("R1", int'(viol), int'(viol_code), 0, 0);
    rst_n = 1'b1;
    idle_check("R2");

    // R1 / R4: empty block accepts any page
    do_op(0, 0, 3, 1, "R1");
    idle_check("R2");
    // R6: partials up to the cap, then overflow
    do_op(0, 0, 3, 1, "R6");
    do_op(0, 0, 3, 1, "R6");
    do_op(0, 0, 3, 1, "R6");
    do_op(0, 0, 3, 1, "R6");
    // R5: lower page
    do_op(0, 0, 2, 1, "R5");
    // R4: higher page resets partial count
    do_op(0, 0, 5, 1, "R4");
    do_op(0, 0, 5, 1, "R6");
    // R8: other block unaffected
    do_op(0, 1, 0, 1, "R8");
    do_op(0, 0, 4, 1, "R8");
    // R9: wp beats order
    do_op(0, 0, 1, 0, "R9");
    // R3: erase under wp changes nothing
    do_op(1, 0, 0, 0, "R3");
    do_op(0, 0, 1, 1, "R3");
    // R7: erase empties block, low page legal again, full partial budget
    do_op(1, 0, 0, 1, "R7");
    do_op(0, 0, 0, 1, "R7");
    do_op(0, 0, 0, 1, "R7");
    do_op(0, 0, 0, 1, "R7");
    do_op(0, 0, 0, 1, "R7");
    idle_check("R2");

    // Sweep: every block, every ordered page pair, from a fresh erase
    for (int b = 0; b < NB; b++)
      for (int p1 = 0; p1 < NP; p1++)
        for (int p2 = 0; p2 < NP; p2++) begin
          do_op(1, b, 0, 1, "");
          do_op(0, b, p1, 1, "");
          do_op(0, b, p2, 1, "");
          do_op(0, b, p2, 1, "");
        end

    // Random phase clustered around the current highest page
    for (int n = 0; n < 4000; n++) begin
      int b, k, p;
      b = int'($urandom_range(0, NB - 1));
      k = int'($urandom_range(0, 19));
      p = m_hi[b] + int'($urandom_range(0, 3)) - 1;
      if (p < 0) p = 0;
      if (p > NP - 1) p = NP - 1;
      if (k == 0)      do_op(1, b, 0, 1, "");
      else if (k == 1) do_op(0, b, p, 0, "");
      else if (k == 2) do_op(1, b, 0, 0, "");
      else             do_op(0, b, p, 1, "");
      if (k == 3) idle_check("R2");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule